// File: doc/BRIEF.md
# Paged Receive Ring Buffer with Byte-Port Readout

This block stores the bytes of incoming frames in a circular region of buffer RAM. The RAM is organised in pages. Two page registers bound the ring: the first page, and an exclusive limit page that is never written. A write-page register marks where the next frame goes. A boundary register marks the last page the host has consumed. Each stored frame starts at offset 0 of its first page with a 4-byte header, and its data follows from offset 4. When a frame completes, the write page moves to the page after the frame. If the frame would run into the boundary page, the frame is dropped and an overflow event is raised instead.

The host drains the ring through a counted byte port. It loads a remote address (page and offset) and a 16-bit byte count, then writes the launch command. Each read of the data port then returns the byte at the remote address and steps the address and the count. The address wraps around the ring the same way the write side does. When the count reaches zero the port goes idle and a completion event is raised. Events are held in a write-one-to-clear register.

Pages hold 2^OFF_W bytes (16 by default). Addresses are formed as {page, offset}. The RAM holds RAM_PAGES pages, indexed by the low bits of the page number, so pages 0x40 to 0x7F map onto the whole RAM by default.

Top module: `rx_page_ring`

## Requirements
- R1: After reset, the ring first page reads 0x4C, the limit page reads 0x80, the write page reads 0x4D, the boundary reads 0x4C, and the event register, remote address and remote count all read 0.
- R2: Register addresses: 0 command, 1 ring first page, 2 ring limit page, 3 boundary, 4 write page, 5 events, 6 remote offset, 7 remote page, 8 count low byte, 9 count high byte, 10 data port. Each register reads back what was written. The remote offset keeps only its low OFF_W bits.
- R3: A frame's data bytes are stored from offset 4 of the write page. At frame end, offsets 0..3 of that page receive the header: status 0x01, the next page, then the length (data bytes + 4) low byte and high byte. The write page then becomes the next page, and event bit 0 is set.
- R4: When a byte is stored at the last offset of page limit-1, the write position moves to offset 0 of the first page. A frame that ends exactly at the end of a page gives, as its next page, the page after that one.
- R5: A frame is dropped if its write position enters the boundary page, or if its next page equals the boundary. A dropped frame writes no header and leaves the write page unchanged, and event bit 1 is set.
- R6: Writing 0x0A to the command register with a nonzero count starts the byte port. Each data-port read then returns the buffer byte at the remote address, increments the remote offset and decrements the count, both of which can be read back.
- R7: The remote address wraps from the last offset of page limit-1 to offset 0 of the first page.
- R8: When the count reaches zero the port stops and event bit 2 is set. While the port is idle (including after a launch with a zero count), data-port reads return 0x00 and change neither the address nor the count.
- R9: Writing the event register clears each bit written as 1 and keeps the others. An event raised in the same cycle as a clear stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 4 | Register address |
| host_wr | input | 1 | Register write strobe |
| host_wdata | input | 8 | Register write data |
| host_rd | input | 1 | Read strobe (steps the data port when addressed) |
| host_rdata | output | 8 | Read data for host_addr |
| rx_valid | input | 1 | Incoming frame byte valid |
| rx_byte | input | 8 | Incoming frame byte |
| rx_last | input | 1 | Marks the final byte of a frame |

## Verification
The embedded assertions check on every cycle that:
- a completed frame is either committed or dropped, never both;
- a committed frame never leaves the write page equal to the boundary, and the write page takes the committed next-page value;
- an active port always has a nonzero count, each port step takes exactly one from the count, and idle reads leave the address and count unchanged;
- raised events appear in the event register.

Only the bench scenarios can show the actual byte contents:
- header layout and length values;
- wrap at the ring limit on both the write and read sides;
- drop detection both mid-frame and at frame end;
- clear-versus-set priority in the event register.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    typedef logic [7:0] byte_t;

    localparam logic [3:0] A_CMD     = 4'h0;
    localparam logic [3:0] A_RING_LO = 4'h1;
    localparam logic [3:0] A_RING_HI = 4'h2;
    localparam logic [3:0] A_RDPG    = 4'h3;
    localparam logic [3:0] A_WRPG    = 4'h4;
    localparam logic [3:0] A_EVT     = 4'h5;
    localparam logic [3:0] A_RADR_LO = 4'h6;
    localparam logic [3:0] A_RADR_HI = 4'h7;
    localparam logic [3:0] A_RCNT_LO = 4'h8;
    localparam logic [3:0] A_RCNT_HI = 4'h9;
    localparam logic [3:0] A_PORT    = 4'hA;

    localparam byte_t CMD_PORT_GO = 8'h0A;
    localparam byte_t HDR_STATUS  = 8'h01;

    localparam int EV_FRAME = 0;
    localparam int EV_OVF   = 1;
    localparam int EV_RDONE = 2;

    // page after pg inside the ring [first, stop)
    function automatic byte_t ring_next(input byte_t pg, input byte_t first, input byte_t stop);
        byte_t inc;
        inc = pg + 8'd1;
        return (inc == stop) ? first : inc;
    endfunction
endpackage

// File: rtl/rxr_buf.sv
module rxr_buf #(
    parameter int IDX_W = 10,
    parameter int OFF_W = 4
) (
    input  logic                   clk,
    input  logic                   dat_we,
    input  logic [IDX_W-1:0]       dat_idx,
    input  logic [7:0]             dat_byte,
    input  logic                   hdr_we,
    input  logic [IDX_W-OFF_W-1:0] hdr_page,
    input  logic [31:0]            hdr_word,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [7:0]             rd_byte
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int HDR_BYTES = 4;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (dat_we) mem_q[dat_idx] <= dat_byte;
        if (hdr_we) begin
            for (int k = 0; k < HDR_BYTES; k++)
                mem_q[{hdr_page, OFF_W'(k)}] <= hdr_word[8*k +: 8];
        end
    end

    assign rd_byte = mem_q[rd_idx];
endmodule

// File: rtl/rxr_wr.sv
module rxr_wr
    import rxr_pkg::*;
#(
    parameter int OFF_W = 4,
    parameter int PGIDX_W = 6,
    localparam int IDX_W = PGIDX_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_valid,
    input  logic [7:0]         rx_byte,
    input  logic               rx_last,
    input  byte_t              curr,
    input  byte_t              bnry,
    input  byte_t              ring_first,
    input  byte_t              ring_stop,
    output logic               dat_we,
    output logic [IDX_W-1:0]   dat_idx,
    output logic               hdr_we,
    output logic [PGIDX_W-1:0] hdr_page,
    output logic [31:0]        hdr_word,
    output logic               commit,
    output logic               drop,
    output byte_t              next_page
);
    localparam logic [OFF_W-1:0] OFF_DATA = OFF_W'(4);

    typedef struct packed {
        logic               busy;
        logic               dropping;
        byte_t              wpage;
        logic [OFF_W-1:0]   woff;
        logic [15:0]        len;
        logic [PGIDX_W-1:0] fpage;
    } wr_st_t;

    wr_st_t st_q, st_d;

    always_comb begin
        byte_t              cp, cp1;
        logic [OFF_W-1:0]   co, co1;
        logic [15:0]        cl, cl1;
        logic               cd, cd1;
        logic [PGIDX_W-1:0] fp;
        st_d      = st_q;
        dat_we    = 1'b0;
        hdr_we    = 1'b0;
        commit    = 1'b0;
        drop      = 1'b0;
        next_page = curr;
        cp  = st_q.busy ? st_q.wpage    : curr;
        co  = st_q.busy ? st_q.woff     : OFF_DATA;
        cl  = st_q.busy ? st_q.len      : 16'd4;
        cd  = st_q.busy ? st_q.dropping : 1'b0;
        fp  = st_q.busy ? st_q.fpage    : curr[PGIDX_W-1:0];
        co1 = co + 1'b1;
        cp1 = (co1 == '0) ? ring_next(cp, ring_first, ring_stop) : cp;
        cl1 = cl + 16'd1;
        cd1 = cd | ((co1 == '0) && (cp1 == bnry));
        dat_idx  = {cp[PGIDX_W-1:0], co};
        hdr_page = fp;
        if (rx_valid) begin
            dat_we = !cd;
            if (rx_last) begin
                next_page = (co1 == '0) ? cp1 : ring_next(cp1, ring_first, ring_stop);
                if (cd1 || (next_page == bnry)) drop = 1'b1;
                else begin
                    commit = 1'b1;
                    hdr_we = 1'b1;
                end
                st_d.busy = 1'b0;
            end else begin
                st_d.busy     = 1'b1;
                st_d.dropping = cd1;
                st_d.wpage    = cp1;
                st_d.woff     = co1;
                st_d.len      = cl1;
                st_d.fpage    = fp;
            end
        end
        hdr_word = {cl1[15:8], cl1[7:0], next_page, HDR_STATUS};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r5_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({commit, drop}));
    a_r5_no_store_when_dropping: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.dropping) |-> !dat_we);
endmodule

// File: rtl/rxr_rdma.sv
module rxr_rdma
    import rxr_pkg::*;
#(
    parameter int OFF_W = 4,
    parameter int PGIDX_W = 6,
    localparam int IDX_W = PGIDX_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  byte_t            ring_first,
    input  byte_t            ring_stop,
    input  logic             ld_off,
    input  logic             ld_page,
    input  logic             ld_cnt_lo,
    input  logic             ld_cnt_hi,
    input  byte_t            ld_byte,
    input  logic             go,
    input  logic             step,
    output logic             active,
    output byte_t            cur_page,
    output logic [OFF_W-1:0] cur_off,
    output logic [15:0]      cnt,
    output logic [IDX_W-1:0] rd_idx,
    output logic             done
);
    typedef struct packed {
        logic             active;
        byte_t            page;
        logic [OFF_W-1:0] off;
        logic [15:0]      cnt;
    } rd_st_t;

    rd_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (ld_off)    st_d.off       = ld_byte[OFF_W-1:0];
        if (ld_page)   st_d.page      = ld_byte;
        if (ld_cnt_lo) st_d.cnt[7:0]  = ld_byte;
        if (ld_cnt_hi) st_d.cnt[15:8] = ld_byte;
        if (go) begin
            st_d.active = (st_q.cnt != 16'd0);
        end else if (step && st_q.active) begin
            st_d.off = st_q.off + 1'b1;
            if (st_d.off == '0) st_d.page = ring_next(st_q.page, ring_first, ring_stop);
            st_d.cnt = st_q.cnt - 16'd1;
            if (st_q.cnt == 16'd1) begin
                st_d.active = 1'b0;
                done        = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active   = st_q.active;
    assign cur_page = st_q.page;
    assign cur_off  = st_q.off;
    assign cnt      = st_q.cnt;
    assign rd_idx   = {st_q.page[PGIDX_W-1:0], st_q.off};

    logic ld_any;
    assign ld_any = ld_off | ld_page | ld_cnt_lo | ld_cnt_hi | go;

    a_r8_active_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt != 16'd0));
    a_r6_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (active && step && !ld_any) |=> (cnt == $past(cnt) - 16'd1));
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && step && !ld_any) |=> ($stable(cnt) && $stable(cur_off) && $stable(cur_page)));
endmodule

// File: rtl/rx_page_ring.sv
module rx_page_ring
    import rxr_pkg::*;
#(
    parameter int    OFF_W     = 4,
    parameter int    RAM_PAGES = 64,
    parameter byte_t RST_FIRST = 8'h4C,
    parameter byte_t RST_STOP  = 8'h80,
    parameter byte_t RST_CURR  = 8'h4D,
    parameter byte_t RST_BNRY  = 8'h4C
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] host_addr,
    input  logic       host_wr,
    input  logic [7:0] host_wdata,
    input  logic       host_rd,
    output logic [7:0] host_rdata,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       rx_last
);
    localparam int PGIDX_W = $clog2(RAM_PAGES);
    localparam int IDX_W   = PGIDX_W + OFF_W;

    typedef struct packed {
        byte_t cmd;
        byte_t first;
        byte_t stop;
        byte_t bnry;
        byte_t curr;
        byte_t evt;
    } regs_t;

    regs_t rg_q, rg_d;

    logic               w_dat_we, w_hdr_we, w_commit, w_drop;
    logic [IDX_W-1:0]   w_dat_idx;
    logic [PGIDX_W-1:0] w_hdr_page;
    logic [31:0]        w_hdr_word;
    byte_t              w_next;
    logic               r_active, r_done;
    byte_t              r_page;
    logic [OFF_W-1:0]   r_off;
    logic [15:0]        r_cnt;
    logic [IDX_W-1:0]   r_idx;
    logic [7:0]         buf_byte;
    logic               go, step;

    assign go   = host_wr && (host_addr == A_CMD) && (host_wdata == CMD_PORT_GO);
    assign step = host_rd && (host_addr == A_PORT);

    rxr_wr #(.OFF_W(OFF_W), .PGIDX_W(PGIDX_W)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_last(rx_last),
        .curr(rg_q.curr), .bnry(rg_q.bnry),
        .ring_first(rg_q.first), .ring_stop(rg_q.stop),
        .dat_we(w_dat_we), .dat_idx(w_dat_idx),
        .hdr_we(w_hdr_we), .hdr_page(w_hdr_page), .hdr_word(w_hdr_word),
        .commit(w_commit), .drop(w_drop), .next_page(w_next)
    );

    rxr_rdma #(.OFF_W(OFF_W), .PGIDX_W(PGIDX_W)) u_rdma (
        .clk(clk), .rst_n(rst_n),
        .ring_first(rg_q.first), .ring_stop(rg_q.stop),
        .ld_off(host_wr && host_addr == A_RADR_LO),
        .ld_page(host_wr && host_addr == A_RADR_HI),
        .ld_cnt_lo(host_wr && host_addr == A_RCNT_LO),
        .ld_cnt_hi(host_wr && host_addr == A_RCNT_HI),
        .ld_byte(host_wdata), .go(go), .step(step),
        .active(r_active), .cur_page(r_page), .cur_off(r_off),
        .cnt(r_cnt), .rd_idx(r_idx), .done(r_done)
    );

    rxr_buf #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_buf (
        .clk(clk),
        .dat_we(w_dat_we), .dat_idx(w_dat_idx), .dat_byte(rx_byte),
        .hdr_we(w_hdr_we), .hdr_page(w_hdr_page), .hdr_word(w_hdr_word),
        .rd_idx(r_idx), .rd_byte(buf_byte)
    );

    always_comb begin
        byte_t clr, set;
        rg_d = rg_q;
        clr  = '0;
        if (host_wr) begin
            case (host_addr)
                A_CMD:     rg_d.cmd   = host_wdata;
                A_RING_LO: rg_d.first = host_wdata;
                A_RING_HI: rg_d.stop  = host_wdata;
                A_RDPG:    rg_d.bnry  = host_wdata;
                A_WRPG:    rg_d.curr  = host_wdata;
                A_EVT:     clr        = host_wdata;
                default: ;
            endcase
        end
        if (w_commit) rg_d.curr = w_next;
        set = '0;
        set[EV_FRAME] = w_commit;
        set[EV_OVF]   = w_drop;
        set[EV_RDONE] = r_done;
        rg_d.evt = (rg_q.evt & ~clr) | set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rg_q <= '{cmd: 8'h00, first: RST_FIRST, stop: RST_STOP,
                              bnry: RST_BNRY, curr: RST_CURR, evt: 8'h00};
        else        rg_q <= rg_d;
    end

    always_comb begin
        case (host_addr)
            A_CMD:     host_rdata = rg_q.cmd;
            A_RING_LO: host_rdata = rg_q.first;
            A_RING_HI: host_rdata = rg_q.stop;
            A_RDPG:    host_rdata = rg_q.bnry;
            A_WRPG:    host_rdata = rg_q.curr;
            A_EVT:     host_rdata = rg_q.evt;
            A_RADR_LO: host_rdata = 8'(r_off);
            A_RADR_HI: host_rdata = r_page;
            A_RCNT_LO: host_rdata = r_cnt[7:0];
            A_RCNT_HI: host_rdata = r_cnt[15:8];
            A_PORT:    host_rdata = r_active ? buf_byte : 8'h00;
            default:   host_rdata = 8'h00;
        endcase
    end

    a_r3_curr_follows_commit: assert property (@(posedge clk) disable iff (!rst_n)
        w_commit |=> (rg_q.curr == $past(w_next)));
    a_r5_commit_avoids_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        w_commit |-> (w_next != rg_q.bnry));
    a_r5_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        w_drop |=> rg_q.evt[EV_OVF]);
    a_r9_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
        r_done |=> rg_q.evt[EV_RDONE]);
endmodule

// File: tb/rx_page_ring_test.sv
module rx_page_ring_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       host_rd = 1'b0;
    logic [7:0] host_rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_last = 1'b0;

    int total = 0;
    int bad = 0;

    rx_page_ring uut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_last(rx_last)
    );

    always #10 clk = ~clk;

    // {address, write value, expected readback}
    localparam logic [19:0] VEC [10] = '{
        {4'h1, 8'h40, 8'h40}, {4'h2, 8'h44, 8'h44}, {4'h3, 8'h43, 8'h43},
        {4'h4, 8'h40, 8'h40}, {4'h7, 8'h42, 8'h42}, {4'h6, 8'h05, 8'h05},
        {4'h6, 8'h3F, 8'h0F}, {4'h8, 8'h34, 8'h34}, {4'h9, 8'h12, 8'h12},
        {4'h0, 8'h55, 8'h55}
    };

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 v = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic expect_reg(input string tag, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic send_frame(input int k, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_byte  = 8'(k * 16 + i);
            rx_last  = (i == n - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic launch(input logic [7:0] pg, input logic [7:0] off, input logic [15:0] n);
        wr(4'h7, pg); wr(4'h6, off); wr(4'h8, n[7:0]); wr(4'h9, n[15:8]);
        wr(4'h0, 8'h0A);
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog: got hang expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        expect_reg("R1 first", 4'h1, 8'h4C);
        expect_reg("R1 stop", 4'h2, 8'h80);
        expect_reg("R1 curr", 4'h4, 8'h4D);
        expect_reg("R1 bnry", 4'h3, 8'h4C);
        expect_reg("R1 evt", 4'h5, 8'h00);
        expect_reg("R1 cnt", 4'h8, 8'h00);
        expect_reg("R1 radr", 4'h7, 8'h00);

        // R2 register table walk
        for (int i = 0; i < 10; i++) begin
            logic [7:0] v;
            wr(VEC[i][19:16], VEC[i][15:8]);
            rd(VEC[i][19:16], v);
            check("R2 readback", v, VEC[i][7:0]);
        end

        // R3 frame 1: 10 bytes into page 0x40 (ring 0x40..0x43, bnry 0x43)
        send_frame(1, 10);
        expect_reg("R3 curr", 4'h4, 8'h41);
        expect_reg("R3 evt", 4'h5, 8'h01);

        // R6 readout of frame 1
        launch(8'h40, 8'h00, 16'd14);
        expect_reg("R6 port hdr status", 4'hA, 8'h01);
        expect_reg("R6 port hdr next", 4'hA, 8'h41);
        expect_reg("R6 port hdr len lo", 4'hA, 8'h0E);
        expect_reg("R6 port hdr len hi", 4'hA, 8'h00);
        expect_reg("R6 port data0", 4'hA, 8'h10);
        expect_reg("R6 count mid", 4'h8, 8'h09);
        expect_reg("R6 offset mid", 4'h6, 8'h05);
        for (int i = 1; i < 10; i++) expect_reg("R6 port data", 4'hA, 8'(16 + i));
        expect_reg("R8 evt done", 4'h5, 8'h05);
        expect_reg("R8 idle port", 4'hA, 8'h00);
        expect_reg("R8 count zero", 4'h8, 8'h00);
        expect_reg("R8 offset held", 4'h6, 8'h0E);

        // R9 write-one-to-clear
        wr(4'h5, 8'h01);
        expect_reg("R9 partial clear", 4'h5, 8'h04);
        wr(4'h5, 8'hFF);
        expect_reg("R9 full clear", 4'h5, 8'h00);

        // R4 frame 2 crosses a page
        wr(4'h3, 8'h40);
        send_frame(2, 20);
        expect_reg("R4 curr after cross", 4'h4, 8'h43);
        launch(8'h41, 8'h00, 16'd4);
        expect_reg("R3 f2 status", 4'hA, 8'h01);
        expect_reg("R3 f2 next", 4'hA, 8'h43);
        expect_reg("R3 f2 len lo", 4'hA, 8'h18);
        expect_reg("R3 f2 len hi", 4'hA, 8'h00);

        // R4 frame 3 fills page 0x43 exactly, wraps to first page
        wr(4'h3, 8'h41);
        send_frame(3, 12);
        expect_reg("R4 curr exact fill wrap", 4'h4, 8'h40);

        // R7 remote address wraps across the ring limit
        launch(8'h43, 8'h0E, 16'd4);
        expect_reg("R7 byte 43:0E", 4'hA, 8'h3A);
        expect_reg("R7 byte 43:0F", 4'hA, 8'h3B);
        expect_reg("R7 byte 40:00", 4'hA, 8'h01);
        expect_reg("R7 byte 40:01", 4'hA, 8'h41);
        expect_reg("R7 page after wrap", 4'h7, 8'h40);
        expect_reg("R7 offset after wrap", 4'h6, 8'h02);

        // R5 mid-frame drop into boundary page
        wr(4'h5, 8'hFF);
        send_frame(4, 20);
        expect_reg("R5 curr kept", 4'h4, 8'h40);
        expect_reg("R5 evt ovf", 4'h5, 8'h02);
        launch(8'h40, 8'h00, 16'd2);
        expect_reg("R5 header untouched 0", 4'hA, 8'h01);
        expect_reg("R5 header untouched 1", 4'hA, 8'h41);

        // R5 frame-end drop: next page equals boundary
        wr(4'h5, 8'hFF);
        send_frame(5, 5);
        expect_reg("R5 end drop curr", 4'h4, 8'h40);
        expect_reg("R5 end drop evt", 4'h5, 8'h02);

        // R8 launch with zero count
        wr(4'h0, 8'h0A);
        expect_reg("R8 zero count port", 4'hA, 8'h00);
        expect_reg("R8 zero count offset", 4'h6, 8'h02);
        expect_reg("R8 zero count no done", 4'h5, 8'h02);

        // R9 set wins over same-cycle clear
        wr(4'h3, 8'h43);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = 8'h77; rx_last = 1'b1;
        host_addr = 4'h5; host_wdata = 8'hFF; host_wr = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; host_wr = 1'b0;
        expect_reg("R9 set wins", 4'h5, 8'h01);
        expect_reg("R3 single byte curr", 4'h4, 8'h41);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule